// File: doc/BRIEF.md
# Random Replacement Slot Picker

This block picks a slot number for random replacement in a translation cache of `ENTRIES` slots. The low `wired` slots are pinned, so a pick always lands in the window that starts at the pinned count and ends at the top slot. A 32-bit Galois shift register supplies the randomness. Its value is reduced modulo the window width and then offset by the pinned count.

A caller raises `req_i` for one cycle while `busy_o` is low. The block samples the pinned count in that same cycle. Some cycles later it shows the chosen slot on `pick_o`, with `valid_o` high for exactly one cycle. Two picks in a row are never equal. If a candidate matches the last delivered slot, the shift register steps again and a new candidate is reduced. The modulo is a restoring shift-and-subtract that handles one dividend bit per cycle, so no divider is built.

When the window holds one slot or none (pinned count at least `ENTRIES-1`), the block returns the top slot on the next cycle. It skips the repeat rule in that case, so it can never spin forever.

Top module: `rand_index_gen`

## Requirements
- R1: After reset `valid_o` and `busy_o` are low. The shift register holds 1, and the remembered last slot is 0.
- R2: Each step of the shift register shifts it right by one. When the bit shifted out was 1, the result is also XORed with 0xD0000001. Every new candidate uses a freshly stepped value.
- R3: For a pinned count `w` below `ENTRIES-1`, each candidate equals (register value mod (`ENTRIES`-`w`)) + `w`. A delivered slot is therefore never below `w`.
- R4: For a pinned count below `ENTRIES-1`, a delivered slot never equals the previously delivered slot. If it would, the register is stepped again until the candidate differs. Every delivered slot becomes the new remembered slot.
- R5: `valid_o` is high for exactly one cycle per accepted request, and only while `busy_o` is low.
- R6: A request raised while `busy_o` is high is ignored and yields no result.
- R7: With a pinned count of at least `ENTRIES-1`, the top slot `ENTRIES-1` is delivered in the cycle after the request. The shift register does not move, and the top slot becomes the remembered slot.
- R8: A request raised in the cycle in which `valid_o` is high is accepted and produces its own later result.
- R9: The pinned count is sampled at acceptance. Changes on `wired_i` while busy have no effect on the result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | 1 | Request a new pick (sampled when idle) |
| wired_i | input | $clog2(ENTRIES+1) | Number of pinned low slots |
| busy_o | output | 1 | A pick is in progress |
| valid_o | output | 1 | One-cycle marker for `pick_o` |
| pick_o | output | $clog2(ENTRIES) | Chosen slot number |

## Verification
Two events can fall in the same cycle. In one, a delivery coincides with a new request arriving. In the other, a request arrives while a retry restarts the reduction. The bench provokes the first by holding `req_i` high across a delivery. It requires two results, each matching the arithmetic model in sequence. It provokes the second with narrow windows, where a pinned count of `ENTRIES-2` gives two slots and frequent retries, and with a stray request pulse and a changed `wired_i` in mid-computation. There it requires a single result, drawn with the count sampled at acceptance.

// File: rtl/rig_pkg.sv
package rig_pkg;
  localparam int LFSR_W = 32;
  localparam logic [LFSR_W-1:0] LFSR_TAPS = 32'hD000_0001;
  localparam logic [LFSR_W-1:0] LFSR_SEED = 32'h0000_0001;
  // arithmetic helpers work on a fixed 8-bit width that covers up to 64 slots
  localparam int AW = 8;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_STEP,
    ST_REDUCE
  } rig_state_e;

  function automatic logic [LFSR_W-1:0] lfsr_next(input logic [LFSR_W-1:0] s);
    logic [LFSR_W-1:0] sh;
    sh = s >> 1;
    if (s[0]) sh = sh ^ LFSR_TAPS;
    return sh;
  endfunction

  // one restoring-remainder step: bring in one dividend bit, subtract if possible
  function automatic logic [AW-1:0] rem_step(input logic [AW-1:0] rem,
                                             input logic           bit_in,
                                             input logic [AW-1:0] span);
    logic [AW-1:0] t;
    t = {rem[AW-2:0], bit_in};
    if (t >= span) t = t - span;
    return t;
  endfunction
endpackage

// File: rtl/rig_lfsr.sv
module rig_lfsr
  import rig_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              adv_i,
  output logic [LFSR_W-1:0] state_o,
  output logic [LFSR_W-1:0] next_o
);
  logic [LFSR_W-1:0] state_q;

  always_ff @(posedge clk) begin
    if (!rst_n)     state_q <= LFSR_SEED;
    else if (adv_i) state_q <= lfsr_next(state_q);
  end

  assign state_o = state_q;
  assign next_o  = lfsr_next(state_q);
endmodule

// File: rtl/rig_modred.sv
module rig_modred
  import rig_pkg::*;
#(
  parameter int CNT_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [LFSR_W-1:0] dividend_i,
  input  logic [CNT_W-1:0]  span_i,
  output logic              done_o,
  output logic [CNT_W-1:0]  rem_o
);
  localparam int STEP_W = $clog2(LFSR_W + 1);

  logic [LFSR_W-1:0] shreg_q;
  logic [CNT_W-1:0]  rem_q;
  logic [CNT_W-1:0]  span_q;
  logic [STEP_W-1:0] left_q;
  logic              active_q;
  logic [AW-1:0]     rem_nx;

  assign rem_nx = rem_step(AW'(rem_q), shreg_q[LFSR_W-1], AW'(span_q));
  assign done_o = active_q && (left_q == '0);
  assign rem_o  = rem_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shreg_q  <= '0;
      rem_q    <= '0;
      span_q   <= '0;
      left_q   <= '0;
      active_q <= 1'b0;
    end else if (start_i) begin
      shreg_q  <= dividend_i;
      rem_q    <= '0;
      span_q   <= span_i;
      left_q   <= STEP_W'(LFSR_W);
      active_q <= 1'b1;
    end else if (active_q) begin
      if (left_q != '0) begin
        rem_q   <= CNT_W'(rem_nx);
        shreg_q <= shreg_q << 1;
        left_q  <= left_q - 1'b1;
      end else begin
        active_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/rand_index_gen.sv
module rand_index_gen
  import rig_pkg::*;
#(
  parameter int ENTRIES = 16,
  localparam int IDX_W = $clog2(ENTRIES),
  localparam int CNT_W = $clog2(ENTRIES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_i,
  input  logic [CNT_W-1:0] wired_i,
  output logic             busy_o,
  output logic             valid_o,
  output logic [IDX_W-1:0] pick_o
);
  rig_state_e        state_q;
  logic [CNT_W-1:0]  wired_q;
  logic [IDX_W-1:0]  prev_q;
  logic [IDX_W-1:0]  pick_q;
  logic              valid_q;

  logic [LFSR_W-1:0] lfsr_q;
  logic [LFSR_W-1:0] lfsr_nx;
  logic [CNT_W-1:0]  rem_w;
  logic [CNT_W-1:0]  span_w;
  logic [CNT_W:0]    sum_w;
  logic [IDX_W-1:0]  cand_w;

  // named internal events
  logic accept_w, degen_w, lfsr_adv_w, div_done_w, retry_w, deliver_w;

  assign accept_w   = req_i && (state_q == ST_IDLE);
  assign degen_w    = int'(wired_i) >= ENTRIES - 1;
  assign lfsr_adv_w = (state_q == ST_STEP);
  assign span_w     = CNT_W'(ENTRIES) - wired_q;
  assign sum_w      = {1'b0, rem_w} + {1'b0, wired_q};
  assign cand_w     = sum_w[IDX_W-1:0];
  assign retry_w    = (state_q == ST_REDUCE) && div_done_w && (cand_w == prev_q);
  assign deliver_w  = (state_q == ST_REDUCE) && div_done_w && (cand_w != prev_q);

  rig_lfsr u_lfsr (
    .clk    (clk),
    .rst_n  (rst_n),
    .adv_i  (lfsr_adv_w),
    .state_o(lfsr_q),
    .next_o (lfsr_nx)
  );

  rig_modred #(.CNT_W(CNT_W)) u_mod (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (lfsr_adv_w),
    .dividend_i(lfsr_nx),
    .span_i    (span_w),
    .done_o    (div_done_w),
    .rem_o     (rem_w)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      wired_q <= '0;
      prev_q  <= '0;
      pick_q  <= '0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (accept_w) begin
            wired_q <= wired_i;
            if (degen_w) begin
              pick_q  <= IDX_W'(ENTRIES - 1);
              prev_q  <= IDX_W'(ENTRIES - 1);
              valid_q <= 1'b1;
            end else begin
              state_q <= ST_STEP;
            end
          end
        end
        ST_STEP: state_q <= ST_REDUCE;
        ST_REDUCE: begin
          if (retry_w) begin
            state_q <= ST_STEP;
          end else if (deliver_w) begin
            pick_q  <= cand_w;
            prev_q  <= cand_w;
            valid_q <= 1'b1;
            state_q <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o  = (state_q != ST_IDLE);
  assign valid_o = valid_q;
  assign pick_o  = pick_q;
endmodule

// File: rtl/rig_checker.sv
module rig_checker
  import rig_pkg::*;
#(
  parameter int ENTRIES = 16,
  localparam int IDX_W = $clog2(ENTRIES),
  localparam int CNT_W = $clog2(ENTRIES + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy_o,
  input logic              valid_o,
  input logic [IDX_W-1:0]  pick_o,
  input logic [CNT_W-1:0]  wired_q,
  input logic              accept_w,
  input logic              degen_w,
  input logic              lfsr_adv_w,
  input logic [LFSR_W-1:0] lfsr_q
);
  logic             open_q;
  logic [IDX_W-1:0] last_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      open_q <= 1'b0;
      last_q <= '0;
    end else begin
      if (accept_w)     open_q <= 1'b1;
      else if (valid_o) open_q <= 1'b0;
      if (valid_o) last_q <= pick_o;
    end
  end

  assert_step_rule_R2: assert property (@(posedge clk) disable iff (!rst_n)
    lfsr_adv_w |=> (lfsr_q == (($past(lfsr_q) >> 1) ^ ($past(lfsr_q[0]) ? LFSR_TAPS : '0))));

  assert_hold_when_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !lfsr_adv_w |=> $stable(lfsr_q));

  assert_window_floor_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && int'(wired_q) < ENTRIES - 1) |-> (int'(pick_o) >= int'(wired_q)));

  assert_no_repeat_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && int'(wired_q) < ENTRIES - 1) |-> (pick_o != last_q));

  assert_result_has_request_R5: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> (open_q && !busy_o));

  assert_no_accept_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
    accept_w |-> (!open_q || valid_o));

  assert_degenerate_top_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (accept_w && degen_w) |=> (valid_o && int'(pick_o) == ENTRIES - 1));

  assert_wired_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && $past(busy_o)) |-> $stable(wired_q));
endmodule

bind rand_index_gen rig_checker #(.ENTRIES(ENTRIES)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .busy_o    (busy_o),
  .valid_o   (valid_o),
  .pick_o    (pick_o),
  .wired_q   (wired_q),
  .accept_w  (accept_w),
  .degen_w   (degen_w),
  .lfsr_adv_w(lfsr_adv_w),
  .lfsr_q    (lfsr_q)
);

// File: tb/rand_index_gen_test.sv
module rand_index_gen_test;
  localparam int N     = 8;
  localparam int IDX_W = $clog2(N);
  localparam int CNT_W = $clog2(N + 1);

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             req_i = 1'b0;
  logic [CNT_W-1:0] wired_i = '0;
  logic             busy_o, valid_o;
  logic [IDX_W-1:0] pick_o;

  int checks = 0;
  int failures = 0;
  int valid_seen = 0;
  bit finished = 0;

  // bench model state
  logic [31:0] m_lfsr = 32'd1;
  int          m_prev = 0;

  always #5 clk = ~clk;

  rand_index_gen #(.ENTRIES(N)) uut (
    .clk(clk), .rst_n(rst_n), .req_i(req_i), .wired_i(wired_i),
    .busy_o(busy_o), .valid_o(valid_o), .pick_o(pick_o)
  );

  always @(negedge clk) if (rst_n && valid_o) valid_seen++;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int model_draw(input int w);
    int c;
    if (w >= N - 1) begin
      m_prev = N - 1;
      return N - 1;
    end
    do begin
      m_lfsr = m_lfsr[0] ? ((m_lfsr >> 1) ^ 32'hD0000001) : (m_lfsr >> 1);
      c = int'(m_lfsr % (N - w)) + w;
    end while (c == m_prev);
    m_prev = c;
    return c;
  endfunction

  task automatic wait_valid(output int lat);
    lat = 0;
    while (!valid_o && lat < 4000) begin
      @(negedge clk);
      lat++;
    end
  endtask

  task automatic run_one(input int w);
    int lat, exp, prev_before;
    prev_before = m_prev;
    @(negedge clk);
    wired_i = CNT_W'(w);
    req_i = 1'b1;
    @(negedge clk);
    req_i = 1'b0;
    wait_valid(lat);
    check(valid_o == 1'b1, "R5 result arrives", int'(valid_o), 1);
    exp = model_draw(w);
    check(int'(pick_o) == exp, "R3 pick matches model", int'(pick_o), exp);
    if (w < N - 1) begin
      check(int'(pick_o) >= w, "R3 pick at or above wired", int'(pick_o), w);
      check(int'(pick_o) != prev_before, "R4 differs from previous", int'(pick_o), prev_before);
    end else begin
      check(lat == 0, "R7 top slot next cycle", lat, 0);
    end
    check(busy_o == 1'b0, "R5 idle with result", int'(busy_o), 0);
    @(negedge clk);
    check(valid_o == 1'b0, "R5 single-cycle valid", int'(valid_o), 0);
  endtask

  initial begin
    #(200000 * 10);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int lat, exp, cnt0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(valid_o == 1'b0, "R1 valid low after reset", int'(valid_o), 0);
    check(busy_o == 1'b0, "R1 busy low after reset", int'(busy_o), 0);

    // R1 R2: first pick after reset from seed 1 and remembered slot 0
    run_one(0);

    // sweep every pinned count, including beyond the degenerate boundary (R3 R4 R7)
    for (int w = 0; w <= N + 1 && w < (1 << CNT_W); w++)
      for (int k = 0; k < 12; k++) run_one(w);

    // R7: degenerate then normal; normal result continues unmoved register
    run_one(N - 1);
    run_one(2);

    // R6 R9: stray request and changed wired count while busy
    cnt0 = valid_seen;
    @(negedge clk);
    wired_i = CNT_W'(2);
    req_i = 1'b1;
    @(negedge clk);
    req_i = 1'b0;
    @(negedge clk);
    wired_i = CNT_W'(5);
    req_i = 1'b1;
    @(negedge clk);
    req_i = 1'b0;
    check(busy_o == 1'b1, "R6 still busy after stray request", int'(busy_o), 1);
    wait_valid(lat);
    exp = model_draw(2);
    check(int'(pick_o) == exp, "R9 uses count sampled at acceptance", int'(pick_o), exp);
    repeat (300) @(negedge clk);
    check(valid_seen - cnt0 == 1, "R6 stray request ignored", valid_seen - cnt0, 1);

    // R8: request held high across a delivery
    cnt0 = valid_seen;
    @(negedge clk);
    wired_i = CNT_W'(3);
    req_i = 1'b1;
    @(negedge clk);
    wait_valid(lat);
    exp = model_draw(3);
    check(int'(pick_o) == exp, "R8 first of back-to-back", int'(pick_o), exp);
    @(negedge clk);
    check(busy_o == 1'b1, "R8 new request accepted at delivery", int'(busy_o), 1);
    req_i = 1'b0;
    wait_valid(lat);
    exp = model_draw(3);
    check(int'(pick_o) == exp, "R8 second of back-to-back", int'(pick_o), exp);
    repeat (300) @(negedge clk);
    check(valid_seen - cnt0 == 2, "R8 two results", valid_seen - cnt0, 2);

    finished = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule